// File: doc/BRIEF.md
# Store Address and Data Unit

This block is the store stage of a 32-bit load/store pipeline. Each cycle it can take one decoded store. The store comes with its addressing form, its access size, the pointer, index and stack-pointer register values, the raw immediate field, two source registers, a condition-pass flag and the current lock flag. One clock edge later the block presents the memory request: the address, 64-bit write data, eight byte-lane strobes and a request valid.

For the auto-modify forms it also returns the new pointer value to be written back to the register file. For the lock-qualified form it returns the new Z flag value. Decoding, condition evaluation, the register file and the memory are outside the block.

Displacements are extended and scaled per form and per size. The lock-qualified form stores only when the lock flag is set. The stack form aligns the stack pointer to a word before adding its offset. The combining form packs a chosen half of each of two registers into one word.

Top module: `stsu_top`

## Requirements
- R1: While `rst` is high, and in the cycle after reset is released, `mem_valid`, `ptr_wb_valid` and `zflag_valid` are low.
- R2: Post-increment (`op_mode`=0): the address is `base_ptr`. `ptr_wb_value` is `base_ptr` plus the access size in bytes: 1, 2, 4 or 8 for `op_size` 0, 1, 2 or 3.
- R3: Pre-decrement (`op_mode`=1): the address and `ptr_wb_value` both equal `base_ptr` minus the access size in bytes.
- R4: Short displacement (`op_mode`=2): the offset added to `base_ptr` is zero-extended. Byte uses `imm_field[2:0]`, halfword uses `imm_field[2:0]`<<1, word uses `imm_field[3:0]`<<2. A doubleword in this form is illegal and is not stored.
- R5: Long displacement (`op_mode`=3): the address is `base_ptr` plus `imm_field[15:0]` sign-extended and unscaled, for every size.
- R6: Indexed (`op_mode`=4): the address is `base_ptr` + (`index_reg` << `index_shift`), with a shift of 0 to 3.
- R7: Conditional (`op_mode`=5): the offset uses `imm_field[8:0]`. Byte sign-extends it unscaled, halfword sign-extends it and shifts left by 1, and word zero-extends it and shifts left by 2. No store happens when `cond_pass` is 0, and a doubleword is illegal.
- R8: With `op_size`=3 the write data is {`src_hi`, `src_lo`} and all eight strobes are set.
- R9: Lock store (`op_mode`=6, always a word): `zflag_valid` is high and `zflag_value` equals `lock_flag`. The store to `base_ptr` + sign-extended `imm_field[15:0]` happens only when `lock_flag` is 1.
- R10: Stack store (`op_mode`=7, word): the address is (`stack_ptr` with bits 1:0 cleared) + (`imm_field[6:0]` zero-extended << 2).
- R11: Combining store (word): the word is {half of `src_lo`, half of `src_hi`}. `half_sel[1]`=1 picks the upper half of `src_lo` and `half_sel[0]`=1 picks the upper half of `src_hi`. `op_mode`=8 addresses `base_ptr` + (`imm_field[7:0]` zero-extended << 2). `op_mode`=9 addresses as in R6.
- R12: Strobe bit k (byte lane k, k=0 is bits 7:0 of `mem_wdata`) is set when k>>size equals `mem_addr[2:0]`>>size. The write data repeats the stored byte, halfword or word across all lanes.
- R13: `ptr_wb_valid` is high only for modes 0 and 1, and only when the store is made. Modes 10 to 15 and illegal size/mode pairs make no store, no writeback and no Z update.
- R14: All outputs are registered and are due one clock after the edge that samples the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A store operation is presented |
| op_mode | input | 4 | Addressing form, codes 0 to 9 |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| base_ptr | input | 32 | Pointer or base register value |
| index_reg | input | 32 | Index register value |
| index_shift | input | 2 | Index left-shift amount |
| stack_ptr | input | 32 | Stack pointer value |
| imm_field | input | 16 | Raw immediate field |
| src_lo | input | 32 | Source register (first register of a pair or combine) |
| src_hi | input | 32 | Next register (upper doubleword half, or second combine register) |
| half_sel | input | 2 | Half selectors for the combining store |
| cond_pass | input | 1 | Condition evaluated true |
| lock_flag | input | 1 | Current lock flag |
| mem_valid | output | 1 | Store request valid |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 64 | Lane-replicated write data |
| mem_strb | output | 8 | Byte-lane write strobes |
| ptr_wb_valid | output | 1 | Pointer writeback valid |
| ptr_wb_value | output | 32 | New pointer value |
| zflag_valid | output | 1 | Z flag update valid |
| zflag_value | output | 1 | New Z flag value |

## Verification
Every output, whether address, data, strobes, writeback or Z update, is due exactly one rising edge after the edge that samples the operation. None takes longer. The bench changes inputs on the falling edge. It then compares all outputs 1 ns after the next rising edge, so each comparison lands in the single cycle its result is due. One explicit check reads the outputs just before that edge, to confirm that no result shows up combinationally.

// File: rtl/stsu_pkg.sv
package stsu_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned BUS_W   = 2 * XLEN;
    localparam int unsigned LANES   = BUS_W / 8;
    localparam int unsigned LANE_AW = $clog2(LANES);
    localparam int unsigned IMM_W   = 16;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } st_size_e;

    typedef enum logic [3:0] {
        AM_POSTINC   = 4'd0,
        AM_PREDEC    = 4'd1,
        AM_SHORT     = 4'd2,
        AM_LONG      = 4'd3,
        AM_INDEX     = 4'd4,
        AM_COND      = 4'd5,
        AM_LOCK      = 4'd6,
        AM_STACK     = 4'd7,
        AM_COMB_DISP = 4'd8,
        AM_COMB_IDX  = 4'd9
    } st_mode_e;

    typedef struct packed {
        logic [XLEN-1:0] offset;
        st_size_e        eff_size;
        logic            legal;
        logic            auto_mod;
        logic            combine;
    } st_form_t;

    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  addr;
        logic [BUS_W-1:0] wdata;
        logic [LANES-1:0] strb;
        logic             wb_valid;
        logic [XLEN-1:0]  wb_value;
        logic             z_valid;
        logic             z_value;
    } st_result_t;

    function automatic logic [XLEN-1:0] size_step(input st_size_e sz);
        return XLEN'(1) << sz;
    endfunction

    function automatic logic [XLEN-1:0] sext_imm16(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext_imm9(input logic [8:0] v);
        return {{(XLEN-9){v[8]}}, v};
    endfunction

endpackage

// File: rtl/stsu_form_decode.sv
module stsu_form_decode
    import stsu_pkg::*;
(
    input  st_mode_e         mode,
    input  st_size_e         size,
    input  logic [IMM_W-1:0] imm,
    output st_form_t         form
);
    logic [XLEN-1:0] off;
    st_size_e        esz;
    logic            ok;

    always_comb begin
        off = '0;
        esz = size;
        ok  = 1'b1;
        unique case (mode)
            AM_POSTINC, AM_PREDEC, AM_INDEX: off = '0;
            AM_SHORT: begin
                unique case (size)
                    SZ_BYTE:  off = XLEN'(imm[2:0]);
                    SZ_HALF:  off = XLEN'({imm[2:0], 1'b0});
                    SZ_WORD:  off = XLEN'({imm[3:0], 2'b00});
                    default:  ok  = 1'b0;
                endcase
            end
            AM_LONG: off = sext_imm16(imm);
            AM_COND: begin
                unique case (size)
                    SZ_BYTE:  off = sext_imm9(imm[8:0]);
                    SZ_HALF:  off = sext_imm9(imm[8:0]) << 1;
                    SZ_WORD:  off = XLEN'({imm[8:0], 2'b00});
                    default:  ok  = 1'b0;
                endcase
            end
            AM_LOCK: begin
                off = sext_imm16(imm);
                esz = SZ_WORD;
            end
            AM_STACK: begin
                off = XLEN'({imm[6:0], 2'b00});
                esz = SZ_WORD;
            end
            AM_COMB_DISP: begin
                off = XLEN'({imm[7:0], 2'b00});
                esz = SZ_WORD;
            end
            AM_COMB_IDX: esz = SZ_WORD;
            default: ok = 1'b0;
        endcase
    end

    assign form.offset   = off;
    assign form.eff_size = esz;
    assign form.legal    = ok;
    assign form.auto_mod = (mode == AM_POSTINC) || (mode == AM_PREDEC);
    assign form.combine  = (mode == AM_COMB_DISP) || (mode == AM_COMB_IDX);

endmodule

// File: rtl/stsu_addr_gen.sv
module stsu_addr_gen
    import stsu_pkg::*;
(
    input  st_mode_e        mode,
    input  st_size_e        eff_size,
    input  logic [XLEN-1:0] ptr,
    input  logic [XLEN-1:0] index,
    input  logic [1:0]      shamt,
    input  logic [XLEN-1:0] sp,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] wb_value
);
    logic [XLEN-1:0] step;
    logic [XLEN-1:0] scaled_idx;
    logic [XLEN-1:0] sp_aligned;

    assign step       = size_step(eff_size);
    assign scaled_idx = index << shamt;
    assign sp_aligned = sp & ~XLEN'(3);

    always_comb begin
        wb_value = ptr;
        unique case (mode)
            AM_POSTINC: begin
                addr     = ptr;
                wb_value = ptr + step;
            end
            AM_PREDEC: begin
                addr     = ptr - step;
                wb_value = ptr - step;
            end
            AM_INDEX, AM_COMB_IDX: addr = ptr + scaled_idx;
            AM_STACK:              addr = sp_aligned + offset;
            default:               addr = ptr + offset;
        endcase
    end

endmodule

// File: rtl/stsu_lane_pack.sv
module stsu_lane_pack
    import stsu_pkg::*;
(
    input  st_size_e           eff_size,
    input  logic [LANE_AW-1:0] addr_lo,
    input  logic               combine,
    input  logic [1:0]         half_sel,
    input  logic [XLEN-1:0]    src_lo,
    input  logic [XLEN-1:0]    src_hi,
    output logic [BUS_W-1:0]   wdata,
    output logic [LANES-1:0]   strb
);
    localparam int unsigned HW = XLEN / 2;

    logic [HW-1:0]   half_a;
    logic [HW-1:0]   half_b;
    logic [XLEN-1:0] word_val;

    assign half_a   = half_sel[1] ? src_lo[XLEN-1:HW] : src_lo[HW-1:0];
    assign half_b   = half_sel[0] ? src_hi[XLEN-1:HW] : src_hi[HW-1:0];
    assign word_val = combine ? {half_a, half_b} : src_lo;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LANE_AW-1:0] LANE_IDX = LANE_AW'(g);
        assign strb[g] = ((LANE_IDX >> eff_size) == (addr_lo >> eff_size));
    end

    always_comb begin
        unique case (eff_size)
            SZ_BYTE:  wdata = {(BUS_W/8){src_lo[7:0]}};
            SZ_HALF:  wdata = {(BUS_W/16){src_lo[15:0]}};
            SZ_WORD:  wdata = {(BUS_W/XLEN){word_val}};
            default:  wdata = {src_hi, src_lo};
        endcase
    end

endmodule

// File: rtl/stsu_top.sv
module stsu_top
    import stsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  op_mode,
    input  logic [1:0]  op_size,
    input  logic [31:0] base_ptr,
    input  logic [31:0] index_reg,
    input  logic [1:0]  index_shift,
    input  logic [31:0] stack_ptr,
    input  logic [15:0] imm_field,
    input  logic [31:0] src_lo,
    input  logic [31:0] src_hi,
    input  logic [1:0]  half_sel,
    input  logic        cond_pass,
    input  logic        lock_flag,
    output logic        mem_valid,
    output logic [31:0] mem_addr,
    output logic [63:0] mem_wdata,
    output logic [7:0]  mem_strb,
    output logic        ptr_wb_valid,
    output logic [31:0] ptr_wb_value,
    output logic        zflag_valid,
    output logic        zflag_value
);
    st_mode_e         mode;
    st_size_e         size;
    st_form_t         form;
    logic [XLEN-1:0]  addr_c;
    logic [XLEN-1:0]  wb_c;
    logic [BUS_W-1:0] wdata_c;
    logic [LANES-1:0] strb_c;
    logic             gate_ok;
    logic             fire;
    st_result_t       nxt;
    st_result_t       q;

    assign mode = st_mode_e'(op_mode);
    assign size = st_size_e'(op_size);

    stsu_form_decode u_decode (
        .mode (mode),
        .size (size),
        .imm  (imm_field),
        .form (form)
    );

    stsu_addr_gen u_addr (
        .mode     (mode),
        .eff_size (form.eff_size),
        .ptr      (base_ptr),
        .index    (index_reg),
        .shamt    (index_shift),
        .sp       (stack_ptr),
        .offset   (form.offset),
        .addr     (addr_c),
        .wb_value (wb_c)
    );

    stsu_lane_pack u_pack (
        .eff_size (form.eff_size),
        .addr_lo  (addr_c[LANE_AW-1:0]),
        .combine  (form.combine),
        .half_sel (half_sel),
        .src_lo   (src_lo),
        .src_hi   (src_hi),
        .wdata    (wdata_c),
        .strb     (strb_c)
    );

    always_comb begin
        unique case (mode)
            AM_COND: gate_ok = cond_pass;
            AM_LOCK: gate_ok = lock_flag;
            default: gate_ok = 1'b1;
        endcase
    end

    assign fire = op_valid && form.legal && gate_ok;

    always_comb begin
        nxt.valid    = fire;
        nxt.addr     = addr_c;
        nxt.wdata    = wdata_c;
        nxt.strb     = strb_c;
        nxt.wb_valid = fire && form.auto_mod;
        nxt.wb_value = wb_c;
        nxt.z_valid  = op_valid && (mode == AM_LOCK);
        nxt.z_value  = lock_flag;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign mem_valid    = q.valid;
    assign mem_addr     = q.addr;
    assign mem_wdata    = q.wdata;
    assign mem_strb     = q.strb;
    assign ptr_wb_valid = q.wb_valid;
    assign ptr_wb_value = q.wb_value;
    assign zflag_valid  = q.z_valid;
    assign zflag_value  = q.z_value;

    // R12
    strb_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ($countones(mem_strb) == 1 || $countones(mem_strb) == 2 ||
                       $countones(mem_strb) == 4 || $countones(mem_strb) == 8));

    // R13
    wb_needs_store_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_wb_valid |-> mem_valid);

    // R9
    lock_z_chk: assert property (@(posedge clk) disable iff (rst)
        zflag_valid |-> (mem_valid == zflag_value));

    // R14
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> $past(op_valid));

    // R2
    postinc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_wb_valid && $past(op_mode) == 4'd0) |->
        (ptr_wb_value == mem_addr + 32'($countones(mem_strb))));

    // R3
    predec_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_wb_valid && $past(op_mode) == 4'd1) |-> (ptr_wb_value == mem_addr));

endmodule

// File: tb/stsu_top_test.sv
`timescale 1ns/1ps
module stsu_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_mode = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] base_ptr = '0;
    logic [31:0] index_reg = '0;
    logic [1:0]  index_shift = '0;
    logic [31:0] stack_ptr = '0;
    logic [15:0] imm_field = '0;
    logic [31:0] src_lo = '0;
    logic [31:0] src_hi = '0;
    logic [1:0]  half_sel = '0;
    logic        cond_pass = 1'b0;
    logic        lock_flag = 1'b0;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_strb;
    logic        ptr_wb_valid;
    logic [31:0] ptr_wb_value;
    logic        zflag_valid;
    logic        zflag_value;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stsu_top uut (
        .clk (clk), .rst (rst), .op_valid (op_valid), .op_mode (op_mode),
        .op_size (op_size), .base_ptr (base_ptr), .index_reg (index_reg),
        .index_shift (index_shift), .stack_ptr (stack_ptr), .imm_field (imm_field),
        .src_lo (src_lo), .src_hi (src_hi), .half_sel (half_sel),
        .cond_pass (cond_pass), .lock_flag (lock_flag), .mem_valid (mem_valid),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_strb (mem_strb),
        .ptr_wb_valid (ptr_wb_valid), .ptr_wb_value (ptr_wb_value),
        .zflag_valid (zflag_valid), .zflag_value (zflag_value)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";  1: return "R3";  2: return "R4";
            3: return "R5";  4: return "R6";  5: return "R7";
            6: return "R9";  7: return "R10"; 8: return "R11";
            9: return "R11"; default: return "R13";
        endcase
    endfunction

    logic [31:0] rng = 32'h1234_5678;
    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Independent model computed from the requirements.
    task automatic check_outputs(input int m, input int sz);
        int          esz = ((m >= 6) && (m <= 9)) ? 2 : sz;
        bit          legal = (m <= 9) && !(sz == 3 && (m == 2 || m == 5));
        bit          gate = (m == 5) ? cond_pass : ((m == 6) ? lock_flag : 1'b1);
        bit          e_valid = legal && gate;
        bit          e_wbv = e_valid && (m <= 1);
        int          nbytes = 1 << esz;
        int          off = 0;
        int          v9;
        logic [31:0] e_addr;
        logic [31:0] e_wb;
        logic [31:0] word_v;
        logic [63:0] e_data;
        logic [7:0]  e_strb;
        int          lane_base;
        string       tag = mode_tag(m);

        case (m)
            2: off = (sz == 0) ? int'(imm_field & 16'h7) :
                     (sz == 1) ? int'(imm_field & 16'h7) * 2 : int'(imm_field & 16'hF) * 4;
            3, 6: off = (imm_field >= 16'h8000) ? int'(imm_field) - 65536 : int'(imm_field);
            5: begin
                v9 = int'(imm_field & 16'h1FF);
                if (sz == 2) off = v9 * 4;
                else begin
                    if (v9 >= 256) v9 = v9 - 512;
                    off = (sz == 1) ? v9 * 2 : v9;
                end
            end
            7: off = int'(imm_field & 16'h7F) * 4;
            8: off = int'(imm_field & 16'hFF) * 4;
            default: off = 0;
        endcase

        e_wb = base_ptr;
        case (m)
            0: begin e_addr = base_ptr; e_wb = base_ptr + 32'(nbytes); end
            1: begin e_addr = base_ptr - 32'(nbytes); e_wb = e_addr; end
            4, 9: e_addr = base_ptr + index_reg * (32'd1 << index_shift);
            7: e_addr = (stack_ptr / 4) * 4 + 32'(off);
            default: e_addr = base_ptr + 32'(off);
        endcase

        word_v = src_lo;
        if (m == 8 || m == 9)
            word_v = {(half_sel[1] ? src_lo[31:16] : src_lo[15:0]),
                      (half_sel[0] ? src_hi[31:16] : src_hi[15:0])};
        lane_base = (int'(e_addr[2:0]) / nbytes) * nbytes;
        e_strb = '0;
        for (int l = 0; l < 8; l++) begin
            if (l >= lane_base && l < lane_base + nbytes) e_strb[l] = 1'b1;
            case (esz)
                0: e_data[l*8 +: 8] = src_lo[7:0];
                1: e_data[l*8 +: 8] = src_lo[(l%2)*8 +: 8];
                2: e_data[l*8 +: 8] = word_v[(l%4)*8 +: 8];
                default: e_data[l*8 +: 8] = (l < 4) ? src_lo[l*8 +: 8] : src_hi[(l-4)*8 +: 8];
            endcase
        end

        chk(e_valid ? tag : "R13", "mem_valid", 64'(mem_valid), 64'(e_valid));
        chk("R13", "ptr_wb_valid", 64'(ptr_wb_valid), 64'(e_wbv));
        chk("R9", "zflag_valid", 64'(zflag_valid), 64'(m == 6));
        if (m == 6) chk("R9", "zflag_value", 64'(zflag_value), 64'(lock_flag));
        if (e_valid) begin
            chk(tag, "mem_addr", 64'(mem_addr), 64'(e_addr));
            chk(esz == 3 ? "R8" : (m >= 8 && m <= 9 ? "R11" : "R12"),
                "mem_wdata", mem_wdata, e_data);
            chk(esz == 3 ? "R8" : "R12", "mem_strb", 64'(mem_strb), 64'(e_strb));
        end
        if (e_wbv) chk(tag, "ptr_wb_value", 64'(ptr_wb_value), 64'(e_wb));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs idle during reset
        chk("R1", "mem_valid in reset", 64'(mem_valid), 64'd0);
        chk("R1", "zflag_valid in reset", 64'(zflag_valid), 64'd0);
        @(negedge clk);
        op_valid = 1'b1; op_mode = 4'd6; lock_flag = 1'b1;
        @(posedge clk); #1;
        chk("R1", "mem_valid with rst high", 64'(mem_valid), 64'd0);
        @(negedge clk);
        op_valid = 1'b0;
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1", "ptr_wb_valid after release", 64'(ptr_wb_valid), 64'd0);
        chk("R1", "mem_valid after release", 64'(mem_valid), 64'd0);

        // R14: nothing appears before the sampling edge
        @(negedge clk);
        op_valid = 1'b1; op_mode = 4'd3; op_size = 2'd2; base_ptr = 32'h100;
        #1;
        chk("R14", "mem_valid before edge", 64'(mem_valid), 64'd0);
        @(posedge clk); #1;
        chk("R14", "mem_valid after edge", 64'(mem_valid), 64'd1);

        for (int s = 0; s < 24; s++) begin
            rng = next_rng(rng);
            base_ptr  = (s == 0) ? 32'h0 : (s == 1 ? 32'hFFFF_FFFC : rng);
            rng = next_rng(rng);
            index_reg = rng;
            rng = next_rng(rng);
            stack_ptr = rng;
            rng = next_rng(rng);
            imm_field = (s == 0) ? 16'hFFFF : (s == 1 ? 16'h8100 : rng[15:0]);
            src_lo    = next_rng(rng);
            rng = next_rng(src_lo);
            src_hi    = rng;
            for (int m = 0; m < 16; m++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int c = 0; c < 4; c++) begin
                        @(negedge clk);
                        op_valid    = 1'b1;
                        op_mode     = 4'(m);
                        op_size     = 2'(sz);
                        cond_pass   = c[0];
                        lock_flag   = c[1];
                        half_sel    = 2'(c + s);
                        index_shift = 2'(sz + s);
                        @(posedge clk); #1;
                        check_outputs(m, sz);
                    end
                end
            end
        end

        // R13: idle input gives no request
        @(negedge clk);
        op_valid = 1'b0;
        @(posedge clk); #1;
        chk("R13", "mem_valid when idle", 64'(mem_valid), 64'd0);
        chk("R9", "zflag_valid when idle", 64'(zflag_valid), 64'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule